// File: doc/BRIEF.md
# Hybrid Signed-Digit Plus Binary Adder

This block adds two operands of equal width N. One is a radix-2 signed-digit number, in which each digit is +1, 0 or -1. The other is a plain unsigned binary number. The sum comes out as an (N+1)-digit signed-digit number. Each digit position holds one small three-input cell. The cell turns the two bits of its signed digit and its binary bit into a transfer bit, which goes to the position above, and an interim-sum bit, which stays in place. No carry travels further than one position, so the logic depth does not depend on N.

A result digit is formed from two bits. Its positive bit is the transfer bit from the cell one position lower, and its negative bit is the interim-sum bit of its own cell. Result digit 0 therefore has a positive bit of zero, and the top digit N has a negative bit of zero. A parameter selects whether the sum leaves through a register stage. When the register stage is present, it has a valid flag that is delayed together with the data.

Top module: `hybrid_sd_adder`

## Requirements
- R1: A signed-digit operand digit is carried on a positive bit and a negative bit, and its value is positive minus negative. The pair (pos,neg) = (0,0) is 0, (0,1) is -1, (1,0) is +1, and (1,1) is a second encoding of 0.
- R2: For every combination of its three input bits, each cell satisfies pos + y - neg = 2*t - u, where t is its transfer bit and u is its interim-sum bit.
- R3: The interim-sum bit of a cell is the parity (XOR) of its positive, negative and binary input bits.
- R4: When the two bits of a signed digit are equal, the cell's transfer bit equals its binary bit. When they differ, the transfer bit equals the positive bit.
- R5: Result digit i has the transfer bit of cell i-1 as its positive bit and the interim-sum bit of cell i as its negative bit. The positive bit of result digit 0 is always 0, and the negative bit of result digit N is always 0.
- R6: The value of the result, the sum over i of (sum_pos[i] - sum_neg[i]) * 2^i, equals the value of the signed-digit operand plus y_bin, for every input.
- R7: Changing the inputs of position j can change only result digits j and j+1.
- R8: With the register stage (default), asserting rst_n low clears out_valid and both result buses. A sum is captured on a rising edge at which in_valid is 1, and it appears together with out_valid = 1 after that edge. out_valid is 0 after any edge at which in_valid was 0.
- R9: With the register stage, the result buses hold their last captured value across edges at which in_valid is 0, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the register stage |
| in_valid | input | 1 | Operands are valid and the sum is captured |
| x_pos | input | N | Positive bits of the signed-digit operand |
| x_neg | input | N | Negative bits of the signed-digit operand |
| y_bin | input | N | Unsigned binary operand |
| out_valid | output | 1 | The result buses hold a captured sum |
| sum_pos | output | N+1 | Positive bits of the signed-digit result |
| sum_neg | output | N+1 | Negative bits of the signed-digit result |

## Verification
The cell identity check and the whole-row value check run on every evaluation of the combinational logic. They assume that all operand bits are known 0 or 1, and that N is small enough for both sides of the value equation to fit in a 64-bit signed integer. The clocked checks assume that in_valid changes only between rising edges and that reset is held at the start. The stimulus meets all of these conditions: it drives every input at the falling edge, including in_valid, and it starts the run in reset. The operands it uses include the (1,1) zero encoding, every pattern of each single cell, and runs in which in_valid is low while the operands move.

// File: rtl/sd_pkg.sv
package sd_pkg;

    // One signed digit: value = pos - neg
    typedef struct packed {
        logic pos;
        logic neg;
    } sd_digit_t;

    function automatic int digit_value(input sd_digit_t d);
        return int'(d.pos) - int'(d.neg);
    endfunction

endpackage

// File: rtl/ppm_cell.sv
module ppm_cell
    import sd_pkg::*;
(
    input  sd_digit_t xd,
    input  logic      yb,
    output logic      t_pos,
    output logic      u_neg
);
    logic diff;

    assign diff  = xd.pos ^ xd.neg;
    assign u_neg = yb ^ diff;
    // balanced form: transfer does not wait on the interim sum
    assign t_pos = diff ? xd.pos : yb;

    always_comb begin
        AST_CELL_IDENTITY: assert (digit_value(xd) + int'(yb) == 2 * int'(t_pos) - int'(u_neg))
            else $error("cell identity broken"); // R2
    end
endmodule

// File: rtl/sd_adder_row.sv
module sd_adder_row
    import sd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] x_pos,
    input  logic [N-1:0] x_neg,
    input  logic [N-1:0] y_bin,
    output logic [N:0]   r_pos,
    output logic [N:0]   r_neg
);
    logic [N-1:0] t_bits;
    logic [N-1:0] u_bits;

    for (genvar i = 0; i < N; i++) begin : g_cell
        sd_digit_t d;
        assign d = '{pos: x_pos[i], neg: x_neg[i]};
        ppm_cell u_cell (
            .xd    (d),
            .yb    (y_bin[i]),
            .t_pos (t_bits[i]),
            .u_neg (u_bits[i])
        );
    end

    assign r_pos = {t_bits, 1'b0};
    assign r_neg = {1'b0, u_bits};

    if (N <= 60) begin : g_value_check
        always_comb begin : value_chk
            longint lhs;
            longint rhs;
            lhs = longint'(y_bin);
            for (int i = 0; i < N; i++)
                lhs = lhs + (longint'(x_pos[i]) - longint'(x_neg[i])) * (longint'(1) <<< i);
            rhs = 0;
            for (int i = 0; i <= N; i++)
                rhs = rhs + (longint'(r_pos[i]) - longint'(r_neg[i])) * (longint'(1) <<< i);
            AST_ROW_VALUE: assert (lhs == rhs) else $error("row value mismatch"); // R6
        end
    end
endmodule

// File: rtl/sd_out_stage.sv
module sd_out_stage #(
    parameter int W       = 17,
    parameter bit USE_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d_pos,
    input  logic [W-1:0] d_neg,
    output logic         q_valid,
    output logic [W-1:0] q_pos,
    output logic [W-1:0] q_neg
);
    if (USE_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_pos   <= '0;
                q_neg   <= '0;
            end else begin
                q_valid <= d_valid;
                if (d_valid) begin
                    q_pos <= d_pos;
                    q_neg <= d_neg;
                end
            end
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            d_valid |=> q_valid); // R8
        AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !d_valid |=> !q_valid); // R8
        AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !d_valid |=> ($stable(q_pos) && $stable(q_neg))); // R9
    end else begin : g_wire
        assign q_valid = d_valid;
        assign q_pos   = d_pos;
        assign q_neg   = d_neg;
    end
endmodule

// File: rtl/hybrid_sd_adder.sv
module hybrid_sd_adder #(
    parameter int N       = 16,
    parameter bit USE_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] x_pos,
    input  logic [N-1:0] x_neg,
    input  logic [N-1:0] y_bin,
    output logic         out_valid,
    output logic [N:0]   sum_pos,
    output logic [N:0]   sum_neg
);
    localparam int RW = N + 1;

    logic [RW-1:0] row_pos;
    logic [RW-1:0] row_neg;

    sd_adder_row #(.N(N)) u_row (
        .x_pos (x_pos),
        .x_neg (x_neg),
        .y_bin (y_bin),
        .r_pos (row_pos),
        .r_neg (row_neg)
    );

    sd_out_stage #(.W(RW), .USE_REG(USE_REG)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_pos   (row_pos),
        .d_neg   (row_neg),
        .q_valid (out_valid),
        .q_pos   (sum_pos),
        .q_neg   (sum_neg)
    );
endmodule

// File: tb/tb_hybrid_sd_adder.sv
module tb_hybrid_sd_adder;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] x_pos = '0;
    logic [N-1:0] x_neg = '0;
    logic [N-1:0] y_bin = '0;
    logic         out_valid;
    logic [N:0]   sum_pos;
    logic [N:0]   sum_neg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hybrid_sd_adder #(.N(N), .USE_REG(1'b1)) dut (
        .clk, .rst_n, .in_valid, .x_pos, .x_neg, .y_bin,
        .out_valid, .sum_pos, .sum_neg
    );

    function automatic longint sd_val(input logic [N:0] p, input logic [N:0] n, input int w);
        longint v = 0;
        for (int i = 0; i < w; i++)
            v = v + (longint'(p[i]) - longint'(n[i])) * (longint'(1) <<< i);
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at falling edge, captured at next rising edge, sample at following falling edge
    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] n, input logic [N-1:0] y);
        @(negedge clk);
        x_pos = p; x_neg = n; y_bin = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 reset valid", longint'(out_valid), 0);
        check("R8 reset pos", longint'(sum_pos), 0);
        check("R8 reset neg", longint'(sum_neg), 0);
    endtask

    task automatic t_cell_exhaustive();
        for (int j = 0; j < N; j++) begin
            for (int c = 0; c < 8; c++) begin
                logic xp, xn, yb, t_exp, u_exp;
                xp = c[2]; xn = c[1]; yb = c[0];
                u_exp = xp ^ xn ^ yb;                   // R3
                t_exp = (xp == xn) ? yb : xp;           // R4
                apply(N'(xp) << j, N'(xn) << j, N'(yb) << j);
                check("R3 interim bit", longint'(sum_neg[j]), longint'(u_exp));
                check("R4 transfer bit", longint'(sum_pos[j+1]), longint'(t_exp));
                // R2 identity observed at the ports
                check("R2 cell identity",
                      2 * longint'(sum_pos[j+1]) - longint'(sum_neg[j]),
                      longint'(xp) + longint'(yb) - longint'(xn));
            end
        end
    endtask

    task automatic t_encoding();
        // R1: all digits (1,1) read as zero, result equals y
        apply('1, '1, 16'h00A5);
        check("R1 double-one zero", sd_val(sum_pos, sum_neg, N+1), 165);
        // R1: all digits (0,1) = -(2^N - 1)
        apply('0, '1, '0);
        check("R1 minus ones", sd_val(sum_pos, sum_neg, N+1), -65535);
        // R1: all digits (1,0) plus all-ones y
        apply('1, '0, '1);
        check("R1 plus ones", sd_val(sum_pos, sum_neg, N+1), 131070);
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [N-1:0] p, n, y, m;
            longint xv;
            p = N'($urandom); n = N'($urandom); y = N'($urandom); m = N'($urandom);
            n = n | (p & m);   // force some (1,1) zero encodings
            xv = sd_val({1'b0, p}, {1'b0, n}, N);
            apply(p, n, y);
            check("R6 sum value", sd_val(sum_pos, sum_neg, N+1), xv + longint'(y));
            check("R5 edge bits", longint'({sum_pos[0], sum_neg[N]}), 0);
            check("R8 valid after capture", longint'(out_valid), 1);
        end
    endtask

    task automatic t_locality();
        for (int j = 0; j < N; j++) begin
            logic [N-1:0] p, n, y;
            logic [N:0] p1, n1, allowed, diff;
            p = N'($urandom); n = N'($urandom); y = N'($urandom);
            apply(p, n, y);
            p1 = sum_pos; n1 = sum_neg;
            apply(p ^ (N'(1) << j), n, y ^ (N'(1) << j));
            diff = (p1 ^ sum_pos) | (n1 ^ sum_neg);
            allowed = (N+1)'(3) << j;
            check("R7 locality", longint'(diff & ~allowed), 0);
        end
    endtask

    task automatic t_hold();
        logic [N:0] p1, n1;
        apply(16'h1234, 16'h0F0F, 16'hBEEF);
        p1 = sum_pos; n1 = sum_neg;
        @(negedge clk);   // one more edge with in_valid low, operands changed
        x_pos = 16'hFFFF; x_neg = 16'h0000; y_bin = 16'h5555;
        @(negedge clk);
        check("R8 valid drops", longint'(out_valid), 0);
        check("R9 pos held", longint'(sum_pos), longint'(p1));
        check("R9 neg held", longint'(sum_neg), longint'(n1));
        check("R6 held value", sd_val(sum_pos, sum_neg, N+1),
              sd_val({1'b0, 16'h1234}, {1'b0, 16'h0F0F}, N) + 48879);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle valid", longint'(out_valid), 0);
        t_cell_exhaustive();
        t_encoding();
        t_random();
        t_locality();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule